// File: doc/BRIEF.md
# DS3 C-bit Serial Access Port

This block sits beside a DS3 framer running C-bit parity framing. It gives outside logic bit-serial access to chosen C-bits of each M-frame. The framer numbers the 21 C-bits of an M-frame 1 to 21 in transmission order, three per subframe across seven subframes. It reports each one with a one-cycle strobe, the index, and on the receive side the bit's value. The block maps a fixed set of indices onto two serial ports. The general port carries indices 2, 4, 5, 6 and 16 to 21, which is ten bits per frame. The data-link port carries indices 13, 14 and 15. Each port has a gapped clock that pulses only at its own positions, and the general port also has a sync flag that marks index 2.

On the transmit side the same gapped clocks go out to a serial source, which returns one data bit per pulse. The block keeps the last value captured for each position. At the next strobe for that index it hands the value back to the framer with a valid flag, so that the framer can insert it. Insertion happens only when parity framing is selected and the enable for that port is set. Otherwise the framer's own default bit is passed back unchanged.

Top module: `ds3_cbit_port`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, every gapped clock, both sync flags, both receive data outputs and `txBitValid` are 0.
- R2: After reset, strobes produce no clock pulse and no insertion until a strobe with index 1 has been seen. Receive data is not updated before that strobe either.
- R3: Once started, a strobe with index in {2,4,5,6,16..21} makes `rxCbClk` and `txCbClk` high for exactly the next cycle. `rxCbData` takes that strobe's `rxBit` in the same cycle and holds it until the next general-port pulse.
- R4: `rxCbSync` and `txCbSync` are high only in the pulse cycle that follows a strobe with index 2.
- R5: Once started, a strobe with index in {13,14,15} makes `rxDlClk` and `txDlClk` high for exactly the next cycle. `rxDlData` takes that strobe's `rxBit` and holds it until the next data-link pulse.
- R6: Strobes with index 1, 3, 7..12, 0 or 22..31 produce no pulse on either port.
- R7: The value on `txCbData` in a cycle where `txCbClk` is high is stored for that index. At the next strobe of the same index, while `parityMode` and `cbInsEn` are 1, the block drives `txBitValid`=1 and `txBit`=stored value in the strobe cycle.
- R8: The same capture and return applies to the data-link positions with `txDlData`, `txDlClk` and `dlInsEn`.
- R9: In any other case `txBitValid`=0 and `txBit` equals `txDefault`. This covers no strobe, a non-port index, `parityMode`=0, a cleared enable, and no capture since reset.
- R10: A strobe for an index in the same cycle as the capture for that index returns the previously stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cbStrobe | input | 1 | One-cycle strobe per C-bit from the framer |
| cbIndex | input | 5 | C-bit index 1..21 for the strobe |
| rxBit | input | 1 | Received value of the strobed C-bit |
| txDefault | input | 1 | Framer's own transmit value for the strobed C-bit |
| parityMode | input | 1 | 1 selects C-bit parity framing |
| cbInsEn | input | 1 | Enables insertion from the general port |
| dlInsEn | input | 1 | Enables insertion from the data-link port |
| rxCbClk | output | 1 | Gapped clock, receive general port |
| rxCbData | output | 1 | Serial data, receive general port |
| rxCbSync | output | 1 | Index-2 marker, receive general port |
| rxDlClk | output | 1 | Gapped clock, receive data-link port |
| rxDlData | output | 1 | Serial data, receive data-link port |
| txCbClk | output | 1 | Gapped clock, transmit general port |
| txCbSync | output | 1 | Index-2 marker, transmit general port |
| txCbData | input | 1 | Serial data, transmit general port |
| txDlClk | output | 1 | Gapped clock, transmit data-link port |
| txDlData | input | 1 | Serial data, transmit data-link port |
| txBit | output | 1 | Value returned to the framer for the strobed C-bit |
| txBitValid | output | 1 | High when txBit is a captured replacement |

## Verification
Two functions can meet in one cycle. One is the capture of a serial bit while a gapped clock is high. The other is the return of a stored value for the strobe arriving in that same cycle. The bench sweeps whole frames with gaps of zero, one and two idle cycles between strobes, so back-to-back strobes put a capture and a return in every cycle. It also strobes one index twice in a row, so that a capture and a return hit the same stored slot. A model in the bench updates its copy of the stored values only after it has compared the returned bit. It therefore expects the older value, and each mismatch is reported with its requirement.

// File: rtl/cbport_pkg.sv
package cbport_pkg;
  localparam int IDX_W = 5;
  localparam int CB_SLOTS = 10;
  localparam int DL_SLOTS = 3;
  localparam int CB_SLOT_W = $clog2(CB_SLOTS);
  localparam int DL_SLOT_W = $clog2(DL_SLOTS);
  localparam int START_INDEX = 1;
  localparam int SYNC_INDEX = 2;

  typedef struct packed {
    logic cbHit;
    logic dlHit;
    logic isSync;
    logic [CB_SLOT_W-1:0] cbSlot;
    logic [DL_SLOT_W-1:0] dlSlot;
  } slotSel_t;

  typedef struct packed {
    slotSel_t now;    // strobe in this cycle, decoded and gated
    slotSel_t pulse;  // strobe of the previous cycle: gapped clock phase
  } ctlStrobes_t;

  function automatic slotSel_t decodeIndex(input logic [IDX_W-1:0] idx);
    slotSel_t s;
    s = '0;
    if (idx == IDX_W'(SYNC_INDEX)) begin
      s.cbHit = 1'b1;
      s.isSync = 1'b1;
    end else if (idx >= IDX_W'(4) && idx <= IDX_W'(6)) begin
      s.cbHit = 1'b1;
      s.cbSlot = CB_SLOT_W'(idx - IDX_W'(3));
    end else if (idx >= IDX_W'(16) && idx <= IDX_W'(21)) begin
      s.cbHit = 1'b1;
      s.cbSlot = CB_SLOT_W'(idx - IDX_W'(12));
    end else if (idx >= IDX_W'(13) && idx <= IDX_W'(15)) begin
      s.dlHit = 1'b1;
      s.dlSlot = DL_SLOT_W'(idx - IDX_W'(13));
    end
    return s;
  endfunction
endpackage

// File: rtl/cbport_ctrl.sv
module cbport_ctrl
  import cbport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cbStrobe,
  input  logic [IDX_W-1:0] cbIndex,
  output ctlStrobes_t      ctl
);
  logic started;
  slotSel_t decoded;
  slotSel_t nowSel;
  slotSel_t pulseQ;

  always_comb begin
    decoded = decodeIndex(cbIndex);
    nowSel = decoded;
    if (!(cbStrobe && started)) begin
      nowSel.cbHit = 1'b0;
      nowSel.dlHit = 1'b0;
      nowSel.isSync = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      pulseQ <= '0;
    end else begin
      if (cbStrobe && cbIndex == IDX_W'(START_INDEX)) started <= 1'b1;
      pulseQ <= nowSel;
    end
  end

  assign ctl.now = nowSel;
  assign ctl.pulse = pulseQ;
endmodule

// File: rtl/cbport_dp.sv
module cbport_dp
  import cbport_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t ctl,
  input  logic        rxBit,
  input  logic        txDefault,
  input  logic        cbInsOn,
  input  logic        dlInsOn,
  input  logic        txCbData,
  input  logic        txDlData,
  output logic        rxCbData,
  output logic        rxDlData,
  output logic        txBit,
  output logic        txBitValid
);
  logic [CB_SLOTS-1:0] capCb, haveCb;
  logic [DL_SLOTS-1:0] capDl, haveDl;
  logic rxCbQ, rxDlQ;
  logic useCb, useDl;

  for (genvar g = 0; g < CB_SLOTS; g++) begin : gCbCap
    always_ff @(posedge clk) begin
      if (rst) begin
        capCb[g] <= 1'b0;
        haveCb[g] <= 1'b0;
      end else if (ctl.pulse.cbHit && ctl.pulse.cbSlot == CB_SLOT_W'(g)) begin
        capCb[g] <= txCbData;
        haveCb[g] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DL_SLOTS; g++) begin : gDlCap
    always_ff @(posedge clk) begin
      if (rst) begin
        capDl[g] <= 1'b0;
        haveDl[g] <= 1'b0;
      end else if (ctl.pulse.dlHit && ctl.pulse.dlSlot == DL_SLOT_W'(g)) begin
        capDl[g] <= txDlData;
        haveDl[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxCbQ <= 1'b0;
      rxDlQ <= 1'b0;
    end else begin
      if (ctl.now.cbHit) rxCbQ <= rxBit;
      if (ctl.now.dlHit) rxDlQ <= rxBit;
    end
  end

  always_comb begin
    useCb = ctl.now.cbHit && cbInsOn && haveCb[ctl.now.cbSlot];
    useDl = ctl.now.dlHit && dlInsOn && haveDl[ctl.now.dlSlot];
    txBitValid = useCb || useDl;
    if (useCb)      txBit = capCb[ctl.now.cbSlot];
    else if (useDl) txBit = capDl[ctl.now.dlSlot];
    else            txBit = txDefault;
  end

  assign rxCbData = rxCbQ;
  assign rxDlData = rxDlQ;
endmodule

// File: rtl/ds3_cbit_port.sv
module ds3_cbit_port
  import cbport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cbStrobe,
  input  logic [IDX_W-1:0] cbIndex,
  input  logic             rxBit,
  input  logic             txDefault,
  input  logic             parityMode,
  input  logic             cbInsEn,
  input  logic             dlInsEn,
  output logic             rxCbClk,
  output logic             rxCbData,
  output logic             rxCbSync,
  output logic             rxDlClk,
  output logic             rxDlData,
  output logic             txCbClk,
  output logic             txCbSync,
  input  logic             txCbData,
  output logic             txDlClk,
  input  logic             txDlData,
  output logic             txBit,
  output logic             txBitValid
);
  ctlStrobes_t ctl;

  cbport_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cbStrobe(cbStrobe), .cbIndex(cbIndex), .ctl(ctl)
  );

  cbport_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rxBit(rxBit), .txDefault(txDefault),
    .cbInsOn(parityMode && cbInsEn), .dlInsOn(parityMode && dlInsEn),
    .txCbData(txCbData), .txDlData(txDlData),
    .rxCbData(rxCbData), .rxDlData(rxDlData),
    .txBit(txBit), .txBitValid(txBitValid)
  );

  assign rxCbClk  = ctl.pulse.cbHit;
  assign txCbClk  = ctl.pulse.cbHit;
  assign rxCbSync = ctl.pulse.isSync;
  assign txCbSync = ctl.pulse.isSync;
  assign rxDlClk  = ctl.pulse.dlHit;
  assign txDlClk  = ctl.pulse.dlHit;
endmodule

// File: rtl/cbport_chk.sv
module cbport_chk (
  input logic       clk,
  input logic       rst,
  input logic       cbStrobe,
  input logic [4:0] cbIndex,
  input logic       parityMode,
  input logic       rxCbClk,
  input logic       rxCbSync,
  input logic       rxCbData,
  input logic       rxDlClk,
  input logic       txBitValid
);
  a_r3_clk_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    rxCbClk |-> $past(cbStrobe));

  a_r3_data_holds: assert property (@(posedge clk) disable iff (rst)
    !rxCbClk |-> $stable(rxCbData));

  a_r4_sync_in_clk: assert property (@(posedge clk) disable iff (rst)
    rxCbSync |-> rxCbClk);

  a_r4_sync_after_c2: assert property (@(posedge clk) disable iff (rst)
    rxCbSync |-> ($past(cbIndex) == 5'd2));

  a_r5_dl_index: assert property (@(posedge clk) disable iff (rst)
    rxDlClk |-> ($past(cbStrobe) && $past(cbIndex) >= 5'd13 && $past(cbIndex) <= 5'd15));

  a_r6_ports_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rxCbClk && rxDlClk));

  a_r9_valid_needs_mode: assert property (@(posedge clk) disable iff (rst)
    txBitValid |-> (parityMode && cbStrobe));
endmodule

bind ds3_cbit_port cbport_chk u_chk (
  .clk(clk), .rst(rst), .cbStrobe(cbStrobe), .cbIndex(cbIndex),
  .parityMode(parityMode), .rxCbClk(rxCbClk), .rxCbSync(rxCbSync),
  .rxCbData(rxCbData), .rxDlClk(rxDlClk), .txBitValid(txBitValid)
);

// File: tb/sim_ds3_cbit_port.sv
`timescale 1ns/1ps
module sim_ds3_cbit_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cbStrobe = 1'b0;
  logic [4:0] cbIndex = '0;
  logic rxBit = 1'b0, txDefault = 1'b0;
  logic parityMode = 1'b0, cbInsEn = 1'b0, dlInsEn = 1'b0;
  logic txCbData = 1'b0, txDlData = 1'b0;
  logic rxCbClk, rxCbData, rxCbSync, rxDlClk, rxDlData;
  logic txCbClk, txCbSync, txDlClk, txBit, txBitValid;

  always #2 clk = ~clk;

  ds3_cbit_port u0 (
    .clk(clk), .rst(rst), .cbStrobe(cbStrobe), .cbIndex(cbIndex), .rxBit(rxBit),
    .txDefault(txDefault), .parityMode(parityMode), .cbInsEn(cbInsEn), .dlInsEn(dlInsEn),
    .rxCbClk(rxCbClk), .rxCbData(rxCbData), .rxCbSync(rxCbSync), .rxDlClk(rxDlClk),
    .rxDlData(rxDlData), .txCbClk(txCbClk), .txCbSync(txCbSync), .txCbData(txCbData),
    .txDlClk(txDlClk), .txDlData(txDlData), .txBit(txBit), .txBitValid(txBitValid)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit mStarted;
  bit mCap[22];
  bit mHave[22];
  bit mRxCb, mRxDl;
  int pIdx;      // index strobed last cycle, -1 if none or gated off
  string pTag;   // requirement tag for the clocks of this cycle
  bit pSer;

  function automatic bit isCb(int i);
    return i == 2 || (i >= 4 && i <= 6) || (i >= 16 && i <= 21);
  endfunction
  function automatic bit isDl(int i);
    return i >= 13 && i <= 15;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic modelClear();
    mStarted = 0; mRxCb = 0; mRxDl = 0; pIdx = -1; pTag = "R1";
    for (int i = 0; i < 22; i++) begin mCap[i] = 0; mHave[i] = 0; end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; cbStrobe = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    modelClear();
    #1;
    check("R1", "rxCbClk", rxCbClk, 0);   check("R1", "txCbClk", txCbClk, 0);
    check("R1", "rxDlClk", rxDlClk, 0);   check("R1", "txDlClk", txDlClk, 0);
    check("R1", "rxCbSync", rxCbSync, 0); check("R1", "txCbSync", txCbSync, 0);
    check("R1", "rxCbData", rxCbData, 0); check("R1", "rxDlData", rxDlData, 0);
    check("R1", "txBitValid", txBitValid, 0);
  endtask

  // One system cycle: drive inputs, compare against model, then advance model.
  task automatic step(bit s, int idx, bit rv, bit td);
    bit hit, expV, expB, ins, same;
    string tTag;
    @(negedge clk);
    cyc++;
    pSer = ((cyc * 5) >> 1) & 1;
    cbStrobe = s; cbIndex = 5'(idx); rxBit = rv; txDefault = td;
    txCbData = pSer; txDlData = ~pSer;
    #1;
    check(pTag, "rxCbClk", rxCbClk, pIdx >= 0 && isCb(pIdx));
    check(pTag, "txCbClk", txCbClk, pIdx >= 0 && isCb(pIdx));
    check(pTag, "rxDlClk", rxDlClk, pIdx >= 0 && isDl(pIdx));
    check(pTag, "txDlClk", txDlClk, pIdx >= 0 && isDl(pIdx));
    check("R4", "rxCbSync", rxCbSync, pIdx == 2);
    check("R4", "txCbSync", txCbSync, pIdx == 2);
    check("R3", "rxCbData", rxCbData, mRxCb);
    check("R5", "rxDlData", rxDlData, mRxDl);
    hit = s && mStarted && idx >= 0 && idx < 22 && (isCb(idx) || isDl(idx));
    ins = parityMode && (isCb(idx) ? cbInsEn : dlInsEn);
    expV = hit && ins && mHave[idx];
    expB = expV ? mCap[idx] : td;
    same = hit && pIdx == idx;
    tTag = same ? "R10" : (expV ? (isCb(idx) ? "R7" : "R8") : "R9");
    check(tTag, "txBitValid", txBitValid, expV);
    check(tTag, "txBit", txBit, expB);
    // model of the clock edge ending this cycle
    if (pIdx >= 0) begin
      mCap[pIdx] = isCb(pIdx) ? pSer : ~pSer;
      mHave[pIdx] = 1;
    end
    if (hit && isCb(idx)) mRxCb = rv;
    if (hit && isDl(idx)) mRxDl = rv;
    if (!s) begin pIdx = -1; pTag = "R3"; end
    else if (!mStarted) begin pIdx = -1; pTag = "R2"; end
    else if (hit) begin pIdx = idx; pTag = isCb(idx) ? "R3" : "R5"; end
    else begin pIdx = -1; pTag = "R6"; end
    if (s && idx == 1) mStarted = 1;
  endtask

  initial begin
    #(150000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelClear();
    doReset();
    // R2: port strobes before the start index are ignored
    step(1, 2, 1, 0); step(1, 13, 1, 1); step(1, 4, 1, 0); step(0, 0, 0, 0);
    step(1, 1, 0, 0); step(0, 0, 0, 0);
    for (int mode = 0; mode < 8; mode++) begin
      parityMode = mode[0]; cbInsEn = mode[1]; dlInsEn = mode[2];
      for (int gap = 0; gap < 3; gap++) begin
        for (int fr = 0; fr < 2; fr++) begin
          for (int idx = 1; idx <= 21; idx++) begin
            step(1, idx, 1'(((idx * 3 + mode + gap + fr) >> 1) & 1), 1'((idx + gap + fr) & 1));
            for (int k = 0; k < gap; k++) step(0, 0, 0, 1'(k & 1));
          end
          // R6: indices outside the C-bit range
          step(1, 0, 1, 0); step(1, 22, 0, 1); step(1, 31, 1, 1); step(0, 0, 0, 0);
        end
      end
    end
    // R10: same index twice back to back, capture and return in one cycle
    parityMode = 1; cbInsEn = 1; dlInsEn = 1;
    for (int r = 0; r < 4; r++) begin
      step(1, 4, 1, 0); step(1, 4, 0, 1); step(1, 14, 1, 0); step(1, 14, 0, 1);
      step(0, 0, 0, 0);
    end
    // R2 and R9 after a second reset: captures cleared, no pulses before start
    doReset();
    step(1, 16, 1, 1); step(1, 15, 1, 0); step(0, 0, 0, 0);
    step(1, 1, 0, 0); step(1, 16, 1, 1); step(1, 15, 0, 0); step(0, 0, 0, 0);
    step(1, 16, 0, 0); step(1, 15, 1, 1); step(0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule